// File: doc/BRIEF.md
# Interleaved Dual-Trace Waveform Store

This block captures two analog traces through one shared converter and keeps them in a single on-chip dual-port memory of 1024 bytes. An analog switch in front of the converter alternates between the two inputs. The block drives that switch through `chan_sel` and flips it after every sample it stores. Because the write address also advances by one per stored sample, channel A always lands on even addresses and channel B on odd addresses. Only the upper 8 bits of each 12-bit conversion are kept, which gives 256 vertical levels.

A capture runs in three steps. The display side arms the block. A trigger then starts a run that begins at address 0 with channel A selected. The run stops by itself once all 1024 locations have been written, which is 512 samples per channel. A new run needs a fresh arm.

The display port works independently of capture and at the same time as it. Each read step returns one word. A frame is a full pass over the 512 odd (B) addresses followed by a full pass over the 512 even (A) addresses. Within each pass the slot index is shifted by a horizontal offset and wraps modulo 512. The offset is the difference between the live position-control reading and the reading held at reset. It is taken at each frame boundary.

Top module: `dual_trace_store`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `chan_sel`, `armed`, `capturing`, `done` and `disp_valid` are all 0.
- R2: `arm` in the idle or done state makes `armed` 1 on the next cycle. `trig` while armed makes `capturing` 1 on the next cycle. `trig` while not armed has no effect.
- R3: During a run, the n-th accepted sample (n counted from 0 after the trigger) has bits [11:4] written to address n. `chan_sel` equals the parity of n before that sample is taken (0 = channel A on even addresses, 1 = channel B on odd addresses). Samples outside a run are not stored and leave `chan_sel` unchanged.
- R4: After the 1024th accepted sample the run ends and `done` goes to 1. Further samples and triggers change neither memory nor state until the next `arm`.
- R5: `arm` during a run is ignored, and the run continues.
- R6: Read steps walk a frame of 1024 words: 512 odd-address words (`disp_chan` = 1), then 512 even-address words (`disp_chan` = 0), repeating.
- R7: Read step i of a pass addresses 2*((i + off) mod 512) + parity. `off` holds for a whole frame and is reloaded on the last step of a frame from (pos_now - pos_ref) mod 512. It is 0 for the first frame.
- R8: `pos_ref` is the `pos_now` value present during reset.
- R9: One cycle after a step, `disp_valid` is 1 and `disp_addr` and `disp_data` show the address read and its stored byte. `disp_valid` is 0 in cycles that follow no step.
- R10: Reads during a run return the memory contents as they were before that cycle's write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Converter sample present this cycle |
| smp_data | input | 12 | Converter sample |
| arm | input | 1 | Request a new capture |
| trig | input | 1 | Trigger event |
| chan_sel | output | 1 | Analog switch control, 0 = A, 1 = B |
| armed | output | 1 | Waiting for trigger |
| capturing | output | 1 | Run in progress |
| done | output | 1 | Memory full, capture stopped |
| pos_now | input | 10 | Horizontal position reading |
| disp_step | input | 1 | Issue one display read |
| disp_valid | output | 1 | Display word present |
| disp_addr | output | 10 | Address of display word |
| disp_data | output | 8 | Display word |
| disp_chan | output | 1 | Channel of display word, 1 = B |

## Verification
The hardest case to reach is a read that hits memory while the same run is still overwriting it: the data returned depends on whether that address has been written earlier in the run or is being written in the same cycle. The bench reaches it with a second capture that runs alongside random read steps. Its model takes each expected read before applying the same cycle's write. Offset wrap is driven by changing the position reading just before the last step of a frame, once to a value above the reset reading and once below it. The first read of the next frame then checks the modulo-512 arithmetic in both directions.

// File: rtl/wf_pkg.sv
// Shared definitions for the dual-trace waveform store.
package wf_pkg;
    // Capture controller states.
    typedef enum logic [1:0] {
        CAP_IDLE  = 2'd0,
        CAP_ARMED = 2'd1,
        CAP_RUN   = 2'd2,
        CAP_DONE  = 2'd3
    } cap_state_t;

    // Channel tag / switch codes.
    localparam logic CH_A = 1'b0;
    localparam logic CH_B = 1'b1;
endpackage

// File: rtl/wf_capture.sv
// Capture controller: arm/trigger sequencing, switch control and write
// address generation. Assumes one converter sample per smp_valid pulse,
// taken with the switch position shown by chan_sel in that cycle.
module wf_capture import wf_pkg::*; #(
    parameter int ADC_W  = 12,
    parameter int SMP_W  = 8,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [ADC_W-1:0]  smp_data,
    input  logic              arm,
    input  logic              trig,
    output logic              chan_sel,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [SMP_W-1:0]  wr_data,
    output logic              armed,
    output logic              capturing,
    output logic              done
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

    cap_state_t        st;
    logic [ADDR_W-1:0] waddr;
    logic              csel;

    // Sequence states, advance the address and flip the switch per stored sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= CAP_IDLE;
            waddr <= '0;
            csel  <= CH_A;
        end else begin
            unique case (st)
                CAP_IDLE, CAP_DONE: begin
                    if (arm) st <= CAP_ARMED;
                end
                CAP_ARMED: begin
                    if (trig) begin
                        st    <= CAP_RUN;
                        waddr <= '0;
                        csel  <= CH_A;
                    end
                end
                CAP_RUN: begin
                    if (smp_valid) begin
                        waddr <= waddr + ADDR_W'(1);
                        csel  <= ~csel;
                        if (waddr == LAST_ADDR) st <= CAP_DONE;
                    end
                end
                default: st <= CAP_IDLE;
            endcase
        end
    end

    // Drive the memory write port and status flags.
    always_comb begin
        wr_en     = (st == CAP_RUN) && smp_valid;
        wr_addr   = waddr;
        wr_data   = smp_data[ADC_W-1 -: SMP_W];
        chan_sel  = csel;
        armed     = (st == CAP_ARMED);
        capturing = (st == CAP_RUN);
        done      = (st == CAP_DONE);
    end

    // R3: switch position always matches the parity of the next write slot in a run.
    a_r3_switch_parity: assert property (@(posedge clk) disable iff (!rst_n)
        capturing |-> (chan_sel == wr_addr[0]));

    // R3: sample word must be known when flagged valid.
    a_r3_sample_known: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> !$isunknown(smp_data));

    // R4: writing the top address ends the run.
    a_r4_stop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == LAST_ADDR)) |=> (done && !capturing));

    // R5: an arm during a run that is not finishing leaves it running.
    a_r5_arm_ignored_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        (capturing && arm && !(wr_en && (wr_addr == LAST_ADDR))) |=> capturing);

    // R2: arm from idle or done reaches the armed state.
    a_r2_arm_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !armed && !capturing) |=> armed);
endmodule

// File: rtl/wf_dpram.sv
// Simple dual-port memory: one write port, one registered read port,
// read-before-write when both ports hit the same address. No reset on
// contents.
module wf_dpram #(
    parameter int W  = 8,
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    // Registered read of the old contents and write of the new.
    always_ff @(posedge clk) begin
        if (re) rdata <= mem[raddr];
        if (we) mem[waddr] <= wdata;
    end
endmodule

// File: rtl/wf_scan.sv
// Display read sequencer: odd pass then even pass, each shifted by a
// horizontal offset that is reloaded at every frame boundary. Assumes the
// position reading is stable while reset is held.
module wf_scan import wf_pkg::*; #(
    parameter int ADDR_W = 10,
    parameter int POS_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [POS_W-1:0]  pos_now,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              disp_valid,
    output logic [ADDR_W-1:0] disp_addr,
    output logic              disp_chan
);
    localparam int HALF_W = ADDR_W - 1;

    logic [HALF_W-1:0] idx;
    logic [HALF_W-1:0] off_q;
    logic [HALF_W-1:0] slot;
    logic              pass_even;
    logic              frame_end;
    logic [POS_W-1:0]  pos_ref;

    // Form the read address from slot index, offset and pass parity.
    always_comb begin
        slot      = idx + off_q;
        frame_end = pass_even && (&idx);
        rd_en     = step;
        rd_addr   = {slot, ~pass_even};
    end

    // Advance the scan; hold the reset reading; reload offset at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_ref   <= pos_now;
            off_q     <= '0;
            idx       <= '0;
            pass_even <= 1'b0;
        end else if (step) begin
            idx <= idx + HALF_W'(1);
            if (&idx) pass_even <= ~pass_even;
            if (frame_end) off_q <= HALF_W'(pos_now - pos_ref);
        end
    end

    // Align address and channel tag with the registered memory data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_valid <= 1'b0;
            disp_addr  <= '0;
            disp_chan  <= CH_A;
        end else begin
            disp_valid <= step;
            if (step) begin
                disp_addr <= rd_addr;
                disp_chan <= pass_even ? CH_A : CH_B;
            end
        end
    end

    // R6: the channel tag agrees with the address parity of the word shown.
    a_r6_tag_matches_parity: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> (disp_chan == disp_addr[0]));

    // R9: every step yields exactly one valid word the next cycle.
    a_r9_valid_after_step: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> disp_valid);

    a_r9_no_valid_without_step: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> !disp_valid);

    // R7: the offset holds except on the last step of a frame.
    a_r7_offset_frame_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(step && frame_end) |=> $stable(off_q));
endmodule

// File: rtl/dual_trace_store.sv
// Top of the dual-trace waveform store: capture controller, shared
// interleaved memory and display read sequencer.
module dual_trace_store #(
    parameter int ADC_W  = 12,
    parameter int SMP_W  = 8,
    parameter int ADDR_W = 10,
    parameter int POS_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [ADC_W-1:0]  smp_data,
    input  logic              arm,
    input  logic              trig,
    output logic              chan_sel,
    output logic              armed,
    output logic              capturing,
    output logic              done,
    input  logic [POS_W-1:0]  pos_now,
    input  logic              disp_step,
    output logic              disp_valid,
    output logic [ADDR_W-1:0] disp_addr,
    output logic [SMP_W-1:0]  disp_data,
    output logic              disp_chan
);
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [SMP_W-1:0]  wr_data;
    logic              rd_en;
    logic [ADDR_W-1:0] rd_addr;

    wf_capture #(.ADC_W(ADC_W), .SMP_W(SMP_W), .ADDR_W(ADDR_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .arm(arm), .trig(trig), .chan_sel(chan_sel), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .armed(armed),
        .capturing(capturing), .done(done)
    );

    wf_dpram #(.W(SMP_W), .AW(ADDR_W)) u_mem (
        .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
        .re(rd_en), .raddr(rd_addr), .rdata(disp_data)
    );

    wf_scan #(.ADDR_W(ADDR_W), .POS_W(POS_W)) u_scan (
        .clk(clk), .rst_n(rst_n), .step(disp_step), .pos_now(pos_now),
        .rd_en(rd_en), .rd_addr(rd_addr), .disp_valid(disp_valid),
        .disp_addr(disp_addr), .disp_chan(disp_chan)
    );
endmodule

// File: tb/dual_trace_store_test.sv
module dual_trace_store_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [11:0] smp_data = '0;
    logic        arm = 1'b0;
    logic        trig = 1'b0;
    logic        chan_sel, armed, capturing, done;
    logic [9:0]  pos_now = 10'd100;
    logic        disp_step = 1'b0;
    logic        disp_valid;
    logic [9:0]  disp_addr;
    logic [7:0]  disp_data;
    logic        disp_chan;

    int n_chk = 0;
    int n_fail = 0;

    // Reference model state.
    int mem_m [1024];
    int st_m = 0;            // 0 idle, 1 armed, 2 run, 3 done
    int waddr_m = 0;
    int csel_m = 0;
    int idx_m = 0;
    int peven_m = 0;
    int off_m = 0;
    int pos_ref_m = 100;

    always #5 clk = ~clk;

    dual_trace_store uut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .arm(arm), .trig(trig), .chan_sel(chan_sel), .armed(armed),
        .capturing(capturing), .done(done), .pos_now(pos_now),
        .disp_step(disp_step), .disp_valid(disp_valid), .disp_addr(disp_addr),
        .disp_data(disp_data), .disp_chan(disp_chan)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int rd_addr_m(input int idx, input int off, input int peven);
        return 2 * ((idx + off) % 512) + (peven != 0 ? 0 : 1);
    endfunction

    // One clock cycle: drive at negedge, update model, check at next negedge.
    task automatic tick(input bit v, input logic [11:0] d, input bit stp,
                        input bit a, input bit t, input string dtag);
        int ea; int ed; int ec; int old_st;
        ea = 0; ed = 0; ec = 0;
        smp_valid = v; smp_data = d; disp_step = stp; arm = a; trig = t;
        old_st = st_m;
        if (stp) begin
            ea = rd_addr_m(idx_m, off_m, peven_m);
            ed = mem_m[ea];
            ec = ea % 2;
            if (peven_m != 0 && idx_m == 511) off_m = (int'(pos_now) - pos_ref_m) & 511;
            if (idx_m == 511) peven_m = 1 - peven_m;
            idx_m = (idx_m + 1) % 512;
        end
        case (old_st)
            0, 3: if (a) st_m = 1;
            1: if (t) begin st_m = 2; waddr_m = 0; csel_m = 0; end
            2: if (v) begin
                mem_m[waddr_m] = int'(d[11:4]);
                if (waddr_m == 1023) st_m = 3;
                waddr_m = (waddr_m + 1) % 1024;
                csel_m = 1 - csel_m;
            end
            default: ;
        endcase
        @(posedge clk);
        @(negedge clk);
        check("R3 chan_sel", int'(chan_sel), csel_m);
        check("R2 armed", int'(armed), int'(st_m == 1));
        if (a && old_st == 2)
            check("R5 arm in run ignored", int'(capturing), int'(st_m == 2));
        else
            check("R2 capturing", int'(capturing), int'(st_m == 2));
        check("R4 done", int'(done), int'(st_m == 3));
        check("R9 disp_valid", int'(disp_valid), int'(stp));
        if (stp) begin
            check("R7 disp_addr", int'(disp_addr), ea);
            check("R6 disp_chan", int'(disp_chan), ec);
            check({dtag, " disp_data"}, int'(disp_data), ed);
        end
        smp_valid = 1'b0; disp_step = 1'b0; arm = 1'b0; trig = 1'b0;
    endtask

    // One display frame with random gaps; the position changes before the last step.
    task automatic frame(input logic [9:0] newpos);
        for (int k = 0; k < 1024; k++) begin
            if ($urandom % 5 == 0) tick(1'b0, 12'h0, 1'b0, 1'b0, 1'b0, "R9");
            if (k == 1023) pos_now = newpos;
            tick(1'b0, 12'h0, 1'b1, 1'b0, 1'b0, "R9");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int guard;
        void'($urandom(32'd20240611));
        // R1: outputs during and right after reset.
        repeat (3) @(negedge clk);
        check("R1 chan_sel in reset", int'(chan_sel), 0);
        check("R1 disp_valid in reset", int'(disp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 chan_sel", int'(chan_sel), 0);
        check("R1 armed", int'(armed), 0);
        check("R1 capturing", int'(capturing), 0);
        check("R1 done", int'(done), 0);
        check("R1 disp_valid", int'(disp_valid), 0);

        // R2: trigger while idle has no effect; samples outside a run are dropped.
        tick(1'b1, 12'hFFF, 1'b0, 1'b0, 1'b1, "R2");
        check("R2 trig idle ignored", int'(capturing), 0);
        tick(1'b0, 12'h0, 1'b0, 1'b1, 1'b0, "R2");
        for (int k = 0; k < 5; k++) tick(1'b1, 12'($urandom), 1'b0, 1'b0, 1'b0, "R3");
        check("R3 switch held while armed", int'(chan_sel), 0);
        tick(1'b0, 12'h0, 1'b0, 1'b0, 1'b1, "R2");
        check("R2 run after trigger", int'(capturing), 1);

        // R3/R5: first capture with random gaps and stray arm requests.
        tick(1'b1, 12'hABF, 1'b0, 1'b0, 1'b0, "R3");
        guard = 0;
        while (st_m != 3 && guard < 5000) begin
            tick($urandom % 10 < 7, 12'($urandom), 1'b0, $urandom % 50 == 0, 1'b0, "R3");
            guard++;
        end
        check("R4 run ended", int'(done), 1);

        // R4: samples and triggers after full do nothing.
        for (int k = 0; k < 20; k++) tick(1'b1, 12'($urandom), 1'b0, 1'b0, 1'b1, "R4");
        check("R4 still done", int'(done), 1);

        // R6/R7/R8: frames with offset above and below the reset reading.
        frame(10'd800);
        tick(1'b0, 12'h0, 1'b1, 1'b0, 1'b0, "R9");
        check("R8 first addr of frame 2", int'(disp_addr), 2 * ((800 - 100) & 511) + 1);
        idx_m = idx_m;
        for (int k = 1; k < 1024; k++) begin
            if (k == 1023) pos_now = 10'd30;
            tick(1'b0, 12'h0, 1'b1, 1'b0, 1'b0, "R4");
        end
        tick(1'b0, 12'h0, 1'b1, 1'b0, 1'b0, "R9");
        check("R8 wrapped offset", int'(disp_addr), 2 * ((30 - 100) & 511) + 1);

        // R10: second capture overlapping display reads.
        tick(1'b0, 12'h0, 1'b0, 1'b1, 1'b0, "R2");
        tick(1'b0, 12'h0, 1'b0, 1'b0, 1'b1, "R2");
        guard = 0;
        while (st_m != 3 && guard < 6000) begin
            tick($urandom % 4 != 0, 12'($urandom), $urandom % 2 == 0, 1'b0, 1'b0, "R10");
            guard++;
        end
        check("R4 second run ended", int'(done), 1);
        frame(10'd100);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule